// File: doc/BRIEF.md
# Operand Remap Activation Controller

This block sits beside the issue stage of a vector-prefixed processor. For every instruction it issues, the block decides which operand slots have their index remapping turned on. There are five slots: three sources and two destinations. The block keeps three pieces of state:

- a five-bit enable mask, one bit per slot;
- a packed field of per-slot shape selectors, which it stores but does not decode;
- two mode flags, one for persistent remapping and one for a single pending one-shot.

Issue presents one instruction per cycle. The instruction carries a two-bit kind code and the decoded fields of a remap-configuration or a vector-length-setting instruction.

Remapping runs in one of two modes. In persistent mode, every later vector-prefixed instruction is remapped on the enabled slots. This lasts until a vector-length-setting instruction writes a new maximum length, or a later configuration turns persistence off.

In one-shot mode, the configuration covers only the next instruction, whatever its kind. The configuration and that instruction form an indivisible pair. Because no state is kept that would let an interrupted pair resume, the block raises an interrupt-inhibit signal for the whole gap between the two.

The per-slot enables are combinational from the current instruction and the stored state. The stored state and the inhibit signal change on the clock edge that retires an instruction.

Top module: `remap_activation_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask, the selector field, the persistence flag and the pending flag are all zero. As a result, `slot_en`, `slot_sel`, `persist_on` and `intr_inhibit` all read zero.
- R2: Mask bit i drives `slot_en[i]`, with this fixed slot order:
  - bit 0: first source;
  - bit 1: second source;
  - bit 2: third source;
  - bit 3: primary destination;
  - bit 4: second destination (effective address, store data, or the implicit base-register write of an update-form load/store).
- R3: A configuration instruction (`ins_kind` = 2) loads `cfg_mask` and `cfg_sel` into the stored state, and loads `cfg_persist` into the persistence flag. The new values show on `slot_sel` and `persist_on` from the next cycle. While `ins_valid` is low, the stored state does not change.
- R4: While the persistence flag is set, every vector-prefixed instruction (`ins_kind` = 1) sees `slot_en` equal to the stored mask, for any number of instructions. An all-zero mask therefore enables no slot.
- R5: A configuration with `cfg_persist` = 0 arms a one-shot for exactly the next issued instruction. If that instruction is vector-prefixed, it sees `slot_en` equal to the mask. Later vector-prefixed instructions see zero.
- R6: If the instruction consuming a one-shot is scalar (`ins_kind` = 0) or a length-setting instruction (`ins_kind` = 3), `slot_en` stays zero and the one-shot is spent. The stored selector field remains readable on `slot_sel`.
- R7: `intr_inhibit` rises in the cycle after a non-persistent configuration. It stays high through idle cycles and falls in the cycle after the next instruction issues. A persistent configuration never raises it.
- R8: A length-setting instruction with `vl_new_max` = 1 clears the persistence flag from the next cycle and leaves the mask and selectors unchanged. With `vl_new_max` = 0, the flag is unchanged.
- R9: `slot_en` is zero in three cases: in a cycle without `ins_valid`, for a scalar instruction, and for a configuration or length-setting instruction itself.
- R10: A configuration issued while a one-shot is pending consumes that one-shot and replaces the whole configuration. The persistence and pending flags are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | An instruction issues this cycle |
| ins_kind | input | 2 | 0 scalar, 1 vector-prefixed, 2 remap configuration, 3 vector-length set |
| cfg_sel | input | 10 | Per-slot shape selectors carried by a configuration |
| cfg_mask | input | 5 | Per-slot enable mask carried by a configuration |
| cfg_persist | input | 1 | Configuration requests persistent mode |
| vl_new_max | input | 1 | Length-setting instruction writes a new maximum length |
| slot_en | output | 5 | Remap enable per slot for the current instruction |
| slot_sel | output | 10 | Stored selector field |
| persist_on | output | 1 | Persistence flag |
| intr_inhibit | output | 1 | Interrupts must be held off (one-shot pending) |

## Verification
A pending flag that is stuck or cleared too early shows in two places. `intr_inhibit` changes one cycle after the wrong instruction. A vector-prefixed instruction issued after the one-shot is spent still gets a non-zero `slot_en` in the same cycle it issues. A persistence flag that is not cleared by a new maximum length shows on the very next vector instruction as an unexpected enable. A mask bit wired to the wrong slot shows as soon as a single-bit mask is applied. The bench therefore issues a vector instruction directly after every state change and compares `slot_en` in that cycle.

// File: rtl/remap_ctrl_pkg.sv
// Package: shared types and sizes for the operand remap activation controller.
// Assumes one instruction per cycle at most, presented with a two-bit kind code.
package remap_ctrl_pkg;

    // Kind code carried with each issued instruction.
    typedef enum logic [1:0] {
        KIND_SCALAR = 2'd0,
        KIND_VECTOR = 2'd1,
        KIND_CONFIG = 2'd2,
        KIND_SETLEN = 2'd3
    } ins_kind_t;

    // Default slot counts: three sources, two destinations.
    localparam int DEF_NUM_SRC = 3;
    localparam int DEF_NUM_DST = 2;
    // Default width of one per-slot shape selector.
    localparam int DEF_SEL_W   = 2;

endpackage

// File: rtl/remap_kind_decode.sv
// Module: classifies the issued instruction into one-hot class strobes.
// Assumes ins_kind is meaningful only while ins_valid is high; all strobes are
// forced low otherwise so downstream logic never sees a phantom instruction.
module remap_kind_decode
    import remap_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ins_valid,
    input  logic [1:0] ins_kind,
    output logic       is_vector,
    output logic       is_config,
    output logic       is_setlen,
    output logic       is_scalar
);

    ins_kind_t kind_c;

    // Purpose: map the raw code onto the enum and qualify each class with valid.
    always_comb begin
        kind_c    = ins_kind_t'(ins_kind);
        is_vector = ins_valid && (kind_c == KIND_VECTOR);
        is_config = ins_valid && (kind_c == KIND_CONFIG);
        is_setlen = ins_valid && (kind_c == KIND_SETLEN);
        is_scalar = ins_valid && (kind_c == KIND_SCALAR);
    end

    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_vector, is_config, is_setlen, is_scalar})); // R9
    AST_CLASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> ({is_vector, is_config, is_setlen, is_scalar} == 4'b0)); // R9

endmodule

// File: rtl/remap_mode_state.sv
// Module: holds the enable mask, the selector field and the two mode flags.
// Assumes at most one class strobe is high per cycle (from remap_kind_decode).
// A configuration loads everything; any other issued instruction spends a
// pending one-shot; a length-setting instruction may also drop persistence.
module remap_mode_state #(
    parameter int NSLOT = 5,
    parameter int SELW  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             is_config,
    input  logic             is_setlen,
    input  logic [NSLOT-1:0] cfg_mask,
    input  logic [SELW-1:0]  cfg_sel,
    input  logic             cfg_persist,
    input  logic             vl_new_max,
    output logic [NSLOT-1:0] mask_q,
    output logic [SELW-1:0]  sel_q,
    output logic             persist_q,
    output logic             pending_q
);

    // Purpose: update the configuration registers on each issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            sel_q     <= '0;
            persist_q <= 1'b0;
            pending_q <= 1'b0;
        end else if (ins_valid) begin
            if (is_config) begin
                mask_q    <= cfg_mask;
                sel_q     <= cfg_sel;
                persist_q <= cfg_persist;
                pending_q <= !cfg_persist;
            end else begin
                pending_q <= 1'b0;
                if (is_setlen && vl_new_max) begin
                    persist_q <= 1'b0;
                end
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0) && (sel_q == '0) && !persist_q && !pending_q); // R1
    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && is_config) |=> (mask_q == $past(cfg_mask)) && (sel_q == $past(cfg_sel))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> $stable(mask_q) && $stable(sel_q) && $stable(persist_q)); // R3
    AST_ONESHOT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && ins_valid && !(is_config && !cfg_persist)) |=> !pending_q); // R5
    AST_NEWMAX_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && is_setlen && vl_new_max) |=> !persist_q); // R8
    AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending_q && persist_q)); // R10

endmodule

// File: rtl/remap_slot_gate.sv
// Module: per-slot enable gating. A slot is remapped when its mask bit is set,
// the current instruction is vector-prefixed, and either mode flag is active.
// Assumes is_vector is already qualified with the instruction-valid strobe.
module remap_slot_gate #(
    parameter int NSLOT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_vector,
    input  logic             persist_q,
    input  logic             pending_q,
    input  logic [NSLOT-1:0] mask_q,
    output logic [NSLOT-1:0] slot_en
);

    logic act;

    // Purpose: one shared activation term for all slots.
    always_comb act = is_vector && (persist_q || pending_q);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Purpose: gate slot g with its own mask bit.
        always_comb slot_en[g] = act && mask_q[g];
    end

    AST_EN_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en & ~mask_q) == '0); // R2
    AST_EN_NEEDS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        !is_vector |-> (slot_en == '0)); // R9
    AST_EN_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(persist_q || pending_q) |-> (slot_en == '0)); // R4

endmodule

// File: rtl/remap_activation_ctrl.sv
// Module: top of the operand remap activation controller. Decodes the issued
// instruction, keeps the remap configuration and mode flags, and drives the
// per-slot enables and the interrupt-inhibit signal.
// Assumes issue holds an instruction for exactly one cycle (ins_valid pulse).
module remap_activation_ctrl
    import remap_ctrl_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_DST = DEF_NUM_DST,
    parameter int SEL_W   = DEF_SEL_W,
    localparam int NSLOT  = NUM_SRC + NUM_DST,
    localparam int SELF_W = NSLOT * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [1:0]        ins_kind,
    input  logic [SELF_W-1:0] cfg_sel,
    input  logic [NSLOT-1:0]  cfg_mask,
    input  logic              cfg_persist,
    input  logic              vl_new_max,
    output logic [NSLOT-1:0]  slot_en,
    output logic [SELF_W-1:0] slot_sel,
    output logic              persist_on,
    output logic              intr_inhibit
);

    logic             is_vector, is_config, is_setlen, is_scalar;
    logic [NSLOT-1:0] mask_q;
    logic             persist_q, pending_q;

    remap_kind_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_kind  (ins_kind),
        .is_vector (is_vector),
        .is_config (is_config),
        .is_setlen (is_setlen),
        .is_scalar (is_scalar)
    );

    remap_mode_state #(.NSLOT(NSLOT), .SELW(SELF_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_valid   (ins_valid),
        .is_config   (is_config),
        .is_setlen   (is_setlen),
        .cfg_mask    (cfg_mask),
        .cfg_sel     (cfg_sel),
        .cfg_persist (cfg_persist),
        .vl_new_max  (vl_new_max),
        .mask_q      (mask_q),
        .sel_q       (slot_sel),
        .persist_q   (persist_q),
        .pending_q   (pending_q)
    );

    remap_slot_gate #(.NSLOT(NSLOT)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_vector (is_vector),
        .persist_q (persist_q),
        .pending_q (pending_q),
        .mask_q    (mask_q),
        .slot_en   (slot_en)
    );

    // Purpose: expose mode flags; inhibit tracks the pending one-shot exactly.
    always_comb begin
        persist_on   = persist_q;
        intr_inhibit = pending_q;
    end

    AST_SCALAR_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        is_scalar |-> (slot_en == '0)); // R6
    AST_PERSIST_CFG_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && is_config && cfg_persist) |=> !intr_inhibit); // R7
    AST_ONESHOT_CFG_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && is_config && !cfg_persist) |=> intr_inhibit); // R7

endmodule

// File: tb/tb_remap_activation_ctrl.sv
// Bench: walks a vector table of issued instructions, then directed tests for
// reset, slot ordering and selector retention.
module tb_remap_activation_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0;
    logic [1:0] ins_kind = 2'd0;
    logic [9:0] cfg_sel = '0;
    logic [4:0] cfg_mask = '0;
    logic       cfg_persist = 1'b0;
    logic       vl_new_max = 1'b0;
    logic [4:0] slot_en;
    logic [9:0] slot_sel;
    logic       persist_on;
    logic       intr_inhibit;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    remap_activation_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .ins_kind     (ins_kind),
        .cfg_sel      (cfg_sel),
        .cfg_mask     (cfg_mask),
        .cfg_persist  (cfg_persist),
        .vl_new_max   (vl_new_max),
        .slot_en      (slot_en),
        .slot_sel     (slot_sel),
        .persist_on   (persist_on),
        .intr_inhibit (intr_inhibit)
    );

    // One step: drive fields, expected enable in the issue cycle, expected
    // inhibit and persistence after the edge.
    typedef struct packed {
        logic       v;
        logic [1:0] k;
        logic [4:0] m;
        logic       p;
        logic       nm;
        logic [4:0] en;
        logic       inh;
        logic       pon;
    } step_t;

    localparam int NSTEP = 30;
    localparam step_t TBL [NSTEP] = '{
        '{1'b0, 2'd0, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // idle R9
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // vec, nothing armed R1
        '{1'b1, 2'd2, 5'b00101, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // one-shot cfg R7
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00101, 1'b0, 1'b0}, // consumed R5
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // only once R5
        '{1'b1, 2'd2, 5'b11010, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // cfg R7
        '{1'b0, 2'd0, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // idle keeps inhibit R7
        '{1'b1, 2'd0, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // scalar spends R6
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // spent R6
        '{1'b1, 2'd2, 5'b10011, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b1}, // persistent cfg R7
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b10011, 1'b0, 1'b1}, // R4
        '{1'b0, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // invalid vec R9
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b10011, 1'b0, 1'b1}, // R4 repeat
        '{1'b1, 2'd0, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // scalar R9
        '{1'b1, 2'd3, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // setlen keep R8
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b10011, 1'b0, 1'b1}, // R4
        '{1'b1, 2'd3, 5'b00000, 1'b0, 1'b1, 5'b00000, 1'b0, 1'b0}, // new max R8
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // off R8
        '{1'b1, 2'd2, 5'b11111, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R7
        '{1'b1, 2'd2, 5'b01000, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b1}, // cfg replaces R10
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b01000, 1'b0, 1'b1}, // R10
        '{1'b1, 2'd2, 5'b00001, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R10
        '{1'b1, 2'd3, 5'b00000, 1'b0, 1'b1, 5'b00000, 1'b0, 1'b0}, // setlen spends R6
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0}, // R6
        '{1'b1, 2'd2, 5'b00000, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b1}, // zero mask R4
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b1}, // R4
        '{1'b1, 2'd2, 5'b11111, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b1}, // R3
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b11111, 1'b0, 1'b1}, // R4
        '{1'b1, 2'd2, 5'b10000, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0}, // R3
        '{1'b1, 2'd1, 5'b00000, 1'b0, 1'b0, 5'b10000, 1'b0, 1'b0}  // R5
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Issue one instruction at the falling edge, check slot_en before the
    // rising edge and registered outputs just after it.
    task automatic issue(input logic v, input logic [1:0] k, input logic [4:0] m,
                         input logic [9:0] s, input logic p, input logic nm,
                         input logic [4:0] exp_en, input logic exp_inh,
                         input logic exp_pon, input string req);
        @(negedge clk);
        ins_valid = v; ins_kind = k; cfg_mask = m; cfg_sel = s;
        cfg_persist = p; vl_new_max = nm;
        #1;
        check(req, "slot_en", 32'(slot_en), 32'(exp_en));
        @(posedge clk);
        #1;
        check(req, "intr_inhibit", 32'(intr_inhibit), 32'(exp_inh));
        check(req, "persist_on", 32'(persist_on), 32'(exp_pon));
        ins_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "slot_en", 32'(slot_en), 32'd0);
        check("R1", "slot_sel", 32'(slot_sel), 32'd0);
        check("R1", "persist_on", 32'(persist_on), 32'd0);
        check("R1", "intr_inhibit", 32'(intr_inhibit), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NSTEP; i++) begin
            issue(TBL[i].v, TBL[i].k, TBL[i].m, {TBL[i].m, TBL[i].m}, TBL[i].p,
                  TBL[i].nm, TBL[i].en, TBL[i].inh, TBL[i].pon, "R4/R5/R7 table");
        end

        // R2: single-bit masks, persistent, land on the matching slot.
        for (int b = 0; b < 5; b++) begin
            issue(1'b1, 2'd2, 5'(1 << b), 10'h000, 1'b1, 1'b0, 5'b0, 1'b0, 1'b1, "R2 cfg");
            issue(1'b1, 2'd1, 5'b0, 10'h000, 1'b0, 1'b0, 5'(1 << b), 1'b0, 1'b1, "R2 slot");
        end

        // R3/R6: selector field stored, survives a scalar consuming the one-shot.
        issue(1'b1, 2'd2, 5'b01110, 10'h2A5, 1'b0, 1'b0, 5'b0, 1'b1, 1'b0, "R3 cfg");
        check("R3", "slot_sel", 32'(slot_sel), 32'h2A5);
        issue(1'b1, 2'd0, 5'b0, 10'h000, 1'b0, 1'b0, 5'b0, 1'b0, 1'b0, "R6 scalar");
        check("R6", "slot_sel", 32'(slot_sel), 32'h2A5);

        // R9: the configuration instruction itself gets no enable even when persistent.
        issue(1'b1, 2'd2, 5'b11111, 10'h155, 1'b1, 1'b0, 5'b0, 1'b0, 1'b1, "R9 cfg");
        issue(1'b1, 2'd2, 5'b11111, 10'h155, 1'b1, 1'b0, 5'b0, 1'b0, 1'b1, "R9 cfg self");

        // R8: new maximum keeps mask and selectors, only persistence drops.
        issue(1'b1, 2'd3, 5'b0, 10'h000, 1'b0, 1'b1, 5'b0, 1'b0, 1'b0, "R8 newmax");
        check("R8", "slot_sel", 32'(slot_sel), 32'h155);

        // R1: reset during a pending one-shot clears everything.
        issue(1'b1, 2'd2, 5'b11111, 10'h3FF, 1'b0, 1'b0, 5'b0, 1'b1, 1'b0, "R1 arm");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "intr_inhibit", 32'(intr_inhibit), 32'd0);
        check("R1", "slot_sel", 32'(slot_sel), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(1'b1, 2'd1, 5'b0, 10'h000, 1'b0, 1'b0, 5'b0, 1'b0, 1'b0, "R1 after reset");

        summary();
    end

endmodule